// File: doc/BRIEF.md
# Dual-Channel Over/Undervoltage Gate Override Controller

This block watches two step-down converter channels through digitized comparator flags and overrides their gate commands when a channel leaves its regulation window. A trip above the 120% level latches the channel's high-side gate off and pulls its enable/fault line low. At the same moment it forces the low-side gate on to discharge the output. When that channel falls below the 87% hysteresis point, the low-side gate is parked off for good. Only a power-on-reset clears this shutdown.

A second, non-latching clamp forces the low-side gate on while the sensed enable/fault line is low and the output is above 113%. The clamp lets go once the output is below 87%. After soft-start, an undervoltage condition turns the low-side gate off to prevent negative ringing, unless another fault is present. A two-level temperature flag pair holds both enable/fault lines low with hysteresis. In multiphase mode, a 120% trip on either channel shuts down both channels together.

Every flag input passes through a synchronizer before any state uses it. All outputs are decoded from registered state. The design reacts on the third rising clock edge after an input changes.

Top module: `ovp_dual_ctrl`

## Requirements
- R1: A 120% flag on a channel sets that channel's `hs_off` and `en_pull_lo` bits, and they stay set.
- R2: At a 120% trip the channel's `ls_on` bit rises. Once that channel's 87% flag is seen, `ls_on` falls and `ls_off` is held high permanently.
- R3: The 120% shutdown state is cleared only by `por_n` low. Removing the trip flag, toggling soft-start or changing other inputs leaves `hs_off` set.
- R4: The 120% trip works whether or not `ss_done` is high.
- R5: While `en_sense` is low (0) and `trip_mid` is high, `ls_on` rises. It stays high after `trip_mid` drops, until the 87% flag clears it. With `en_sense` high (1), `trip_mid` has no effect on `ls_on`.
- R6: With `mp_mode`=0, a 120% trip affects only its own channel. With `mp_mode`=1, a 120% trip on either channel sets `hs_off` and `ls_on` on both. Each channel then releases its low side on its own 87% flag.
- R7: `ls_off` from undervoltage equals `ss_done & under_v & ~other_fault & ~trip_mid` for that channel (no 120% trip, thermal hold clear). It is zero before soft-start completes.
- R8: `temp_hot` high sets both `en_pull_lo` bits. They stay set after `temp_hot` falls and clear only when `temp_cool` is high. `temp_hot` wins if both are high.
- R9: Every output responds on the third rising clock edge after an input change, and not on the second.
- R10: When force-on and force-off requests coincide on a channel, `ls_on`=1 and `ls_off`=0.
- R11: After power-on-reset, all outputs are 0.

Bit 0 of every two-bit port belongs to channel 0, and bit 1 belongs to channel 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low asynchronous power-on-reset |
| trip_hi | input | 2 | Output above 120% of target, per channel |
| trip_mid | input | 2 | Output above 113% of target, per channel |
| below_hyst | input | 2 | Output below 87% of target, per channel |
| under_v | input | 2 | Output below the undervoltage level, per channel |
| ss_done | input | 2 | Soft-start finished, per channel |
| en_sense | input | 2 | Sensed enable/fault line level (1 = high), per channel |
| mp_mode | input | 1 | 1 = multiphase coupling, 0 = independent channels |
| temp_hot | input | 1 | Junction above the upper temperature threshold |
| temp_cool | input | 1 | Junction below the lower temperature threshold |
| other_fault | input | 1 | Overcurrent or PLL fault present |
| hs_off | output | 2 | Force high-side gate off |
| ls_on | output | 2 | Force low-side gate on |
| ls_off | output | 2 | Force low-side gate off |
| en_pull_lo | output | 2 | Pull enable/fault line low |

## Verification
The assertions check several properties on every cycle. A tripped latch never releases without reset. The parked low-side state is permanent. The clamp cannot set without its enabling pair of conditions. The undervoltage force stays clear before soft-start. The thermal hold sets on the hot flag and keeps its state until the cool flag. Only the bench scenarios can show the exact three-edge latency and the coupling between channels in multiphase mode. The same applies to the full undervoltage qualification table, the release ordering of the clamps, and the force-on-over-force-off priority.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

  localparam int NCH = 2;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_HOLD = 2'd1,
    LS_PARK = 2'd2
  } ls_phase_t;

  // shutdown trigger for a channel: own trip, or partner trip when coupled
  function automatic logic trip_evt(input logic own, input logic mate,
                                    input logic coupled);
    return own | (coupled & mate);
  endfunction

  // set/reset clamp where the hysteresis release dominates
  function automatic logic clamp_next(input logic q, input logic set,
                                      input logic rel);
    return (q | set) & ~rel;
  endfunction

  // undervoltage force only after soft-start with no blocking fault
  function automatic logic uv_qualify(input logic ssd, input logic uv,
                                      input logic block);
    return ssd & uv & ~block;
  endfunction

  // thermal hold: hot sets (priority), cool clears
  function automatic logic therm_next(input logic q, input logic hot,
                                      input logic cool);
    return hot | (q & ~cool);
  endfunction

endpackage

// File: rtl/ovp_sync.sv
module ovp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[s] <= '0;
          else        chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ovp_thermal.sv
module ovp_thermal
  import ovp_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic hot,
  input  logic cool,
  output logic hold
);

  logic hold_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) hold_q <= 1'b0;
    else        hold_q <= therm_next(hold_q, hot, cool);
  end

  assign hold = hold_q;

  p_therm_set_r8: assert property (@(posedge clk) disable iff (!por_n)
    hot |=> hold_q);

  p_therm_keep_r8: assert property (@(posedge clk) disable iff (!por_n)
    (hold_q && !cool) |=> hold_q);

endmodule

// File: rtl/ovp_chan.sv
module ovp_chan
  import ovp_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic trip_own,
  input  logic trip_mate,
  input  logic mp_mode,
  input  logic over_mid,
  input  logic below_hyst,
  input  logic under_v,
  input  logic ss_done,
  input  logic en_low,
  input  logic ext_fault,
  input  logic therm_hold,
  output logic hs_off,
  output logic ls_on,
  output logic ls_off,
  output logic en_pull_lo
);

  // named internal events
  logic      ov_trip;
  logic      clamp_set;
  logic      uv_block;
  logic      ls_on_req;
  logic      ls_off_req;

  logic      shut_q;
  ls_phase_t phase_q, phase_d;
  logic      clamp_q;
  logic      uv_q;

  assign ov_trip   = trip_evt(trip_own, trip_mate, mp_mode);
  assign clamp_set = en_low & over_mid;
  assign uv_block  = ext_fault | therm_hold | over_mid | shut_q | ov_trip;

  // latched 120% shutdown, cleared only by power-on-reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       shut_q <= 1'b0;
    else if (ov_trip) shut_q <= 1'b1;
  end

  // low-side sequence after a 120% trip
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      LS_IDLE: if (ov_trip)    phase_d = LS_HOLD;
      LS_HOLD: if (below_hyst) phase_d = LS_PARK;
      LS_PARK:                 phase_d = LS_PARK;
      default:                 phase_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) phase_q <= LS_IDLE;
    else        phase_q <= phase_d;
  end

  // non-latching 113% clamp with 87% release
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) clamp_q <= 1'b0;
    else        clamp_q <= clamp_next(clamp_q, clamp_set, below_hyst);
  end

  // undervoltage low-side turn-off
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) uv_q <= 1'b0;
    else        uv_q <= uv_qualify(ss_done, under_v, uv_block);
  end

  assign ls_on_req  = (phase_q == LS_HOLD) | clamp_q;
  assign ls_off_req = (phase_q == LS_PARK) | uv_q;

  assign hs_off     = shut_q;
  assign ls_on      = ls_on_req;
  assign ls_off     = ls_off_req & ~ls_on_req;
  assign en_pull_lo = shut_q | therm_hold;

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    shut_q |=> shut_q);

  p_trip_shut_r1: assert property (@(posedge clk) disable iff (!por_n)
    ov_trip |=> (hs_off && en_pull_lo));

  p_park_sticky_r2: assert property (@(posedge clk) disable iff (!por_n)
    (phase_q == LS_PARK) |=> (phase_q == LS_PARK));

  p_clamp_gate_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!clamp_q && !clamp_set) |=> !clamp_q);

  p_uv_wait_r7: assert property (@(posedge clk) disable iff (!por_n)
    !ss_done |=> !uv_q);

endmodule

// File: rtl/ovp_dual_ctrl.sv
module ovp_dual_ctrl
  import ovp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] trip_hi,
  input  logic [1:0] trip_mid,
  input  logic [1:0] below_hyst,
  input  logic [1:0] under_v,
  input  logic [1:0] ss_done,
  input  logic [1:0] en_sense,
  input  logic       mp_mode,
  input  logic       temp_hot,
  input  logic       temp_cool,
  input  logic       other_fault,
  output logic [1:0] hs_off,
  output logic [1:0] ls_on,
  output logic [1:0] ls_off,
  output logic [1:0] en_pull_lo
);

  localparam int SW = 6 * NCH + 3;

  logic [SW-1:0]  raw, synced;
  logic [NCH-1:0] hi_s, mid_s, below_s, uv_s, ssd_s, en_s;
  logic           hot_s, cool_s, fault_s;
  logic           therm_hold;

  assign raw = {other_fault, temp_cool, temp_hot, en_sense, ss_done,
                under_v, below_hyst, trip_mid, trip_hi};

  ovp_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (raw),
    .q     (synced)
  );

  assign {fault_s, cool_s, hot_s, en_s, ssd_s,
          uv_s, below_s, mid_s, hi_s} = synced;

  ovp_thermal u_therm (
    .clk   (clk),
    .por_n (por_n),
    .hot   (hot_s),
    .cool  (cool_s),
    .hold  (therm_hold)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      localparam int MATE = NCH - 1 - c;
      ovp_chan u_chan (
        .clk        (clk),
        .por_n      (por_n),
        .trip_own   (hi_s[c]),
        .trip_mate  (hi_s[MATE]),
        .mp_mode    (mp_mode),
        .over_mid   (mid_s[c]),
        .below_hyst (below_s[c]),
        .under_v    (uv_s[c]),
        .ss_done    (ssd_s[c]),
        .en_low     (~en_s[c]),
        .ext_fault  (fault_s),
        .therm_hold (therm_hold),
        .hs_off     (hs_off[c]),
        .ls_on      (ls_on[c]),
        .ls_off     (ls_off[c]),
        .en_pull_lo (en_pull_lo[c])
      );
    end
  endgenerate

  p_thermal_both_r8: assert property (@(posedge clk) disable iff (!por_n)
    therm_hold |-> (en_pull_lo == 2'b11));

endmodule

// File: tb/test_ovp_dual_ctrl.sv
module test_ovp_dual_ctrl;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [1:0] trip_hi, trip_mid, below_hyst, under_v, ss_done, en_sense;
  logic       mp_mode, temp_hot, temp_cool, other_fault;
  logic [1:0] hs_off, ls_on, ls_off, en_pull_lo;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  ovp_dual_ctrl i_ovp_dual_ctrl (
    .clk(clk), .por_n(por_n), .trip_hi(trip_hi), .trip_mid(trip_mid),
    .below_hyst(below_hyst), .under_v(under_v), .ss_done(ss_done),
    .en_sense(en_sense), .mp_mode(mp_mode), .temp_hot(temp_hot),
    .temp_cool(temp_cool), .other_fault(other_fault),
    .hs_off(hs_off), .ls_on(ls_on), .ls_off(ls_off), .en_pull_lo(en_pull_lo)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    trip_hi = '0; trip_mid = '0; below_hyst = '0; under_v = '0;
    ss_done = '0; en_sense = 2'b11; mp_mode = 1'b0;
    temp_hot = 1'b0; temp_cool = 1'b0; other_fault = 1'b0;
    @(negedge clk);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    settle();
  endtask

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset();
    chk("R11 hs_off", hs_off, 2'b00);
    chk("R11 ls_on", ls_on, 2'b00);
    chk("R11 ls_off", ls_off, 2'b00);
    chk("R11 en_pull_lo", en_pull_lo, 2'b00);

    // R9 latency, R4 trip before soft-start, R1, R6 dual isolation
    trip_hi = 2'b01;
    repeat (2) @(posedge clk); #1;
    chk("R9 not yet", hs_off, 2'b00);
    @(posedge clk); #1;
    chk("R9 third edge", hs_off, 2'b01);
    chk("R1 en_pull_lo", en_pull_lo, 2'b01);
    chk("R4 ls_on before ss_done", ls_on, 2'b01);
    chk("R6 dual isolation", hs_off[1], 1'b0);
    // R3 removing the trip does not clear
    trip_hi = 2'b00; settle();
    chk("R3 latch holds", hs_off, 2'b01);
    // R2 release to parked off
    below_hyst = 2'b01; settle();
    chk("R2 ls_on released", ls_on, 2'b00);
    chk("R2 ls_off parked", ls_off, 2'b01);
    below_hyst = 2'b00; ss_done = 2'b11; other_fault = 1'b1; settle();
    chk("R2 park permanent", ls_off, 2'b01);
    chk("R3 latch after other inputs", hs_off, 2'b01);
    do_reset();
    chk("R3 por clears", hs_off, 2'b00);
    chk("R11 ls_off after por", ls_off, 2'b00);

    // R6 multiphase coupling
    mp_mode = 1'b1; trip_hi = 2'b10; settle();
    chk("R6 mp hs_off", hs_off, 2'b11);
    chk("R6 mp ls_on", ls_on, 2'b11);
    below_hyst = 2'b01; settle();
    chk("R6 own release ls_on", ls_on, 2'b10);
    chk("R6 own release ls_off", ls_off, 2'b01);

    // R5 clamp gating sweep
    for (int k = 0; k < 4; k++) begin
      do_reset();
      en_sense = {1'b1, k[0]};
      trip_mid = {1'b0, k[1]};
      settle();
      chk("R5 clamp gate", ls_on, {1'b0, ~k[0] & k[1]});
      chk("R5 no shutdown", hs_off, 2'b00);
    end
    // R5 hold and release, R10 priority
    do_reset();
    en_sense = 2'b10; trip_mid = 2'b01; settle();
    trip_mid = 2'b00; ss_done = 2'b01; under_v = 2'b01; settle();
    chk("R5 clamp held", ls_on, 2'b01);
    chk("R10 force-on wins", ls_off, 2'b00);
    below_hyst = 2'b01; under_v = 2'b00; settle();
    chk("R5 clamp released", ls_on, 2'b00);
    below_hyst = 2'b00; settle();
    chk("R5 normal after release", ls_on | ls_off, 2'b00);

    // R7 undervoltage qualification sweep
    for (int k = 0; k < 16; k++) begin
      do_reset();
      ss_done     = {1'b0, k[0]};
      under_v     = {1'b0, k[1]};
      other_fault = k[2];
      trip_mid    = {1'b0, k[3]};
      settle();
      chk("R7 uv table", ls_off, {1'b0, k[0] & k[1] & ~k[2] & ~k[3]});
    end

    // R8 thermal hysteresis
    do_reset();
    temp_hot = 1'b1; settle();
    chk("R8 hot sets", en_pull_lo, 2'b11);
    temp_hot = 1'b0; settle();
    chk("R8 hold", en_pull_lo, 2'b11);
    temp_hot = 1'b1; temp_cool = 1'b1; settle();
    chk("R8 hot priority", en_pull_lo, 2'b11);
    temp_hot = 1'b0; settle();
    chk("R8 cool clears", en_pull_lo, 2'b00);
    chk("R8 no high-side effect", hs_off, 2'b00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule